// File: doc/BRIEF.md
# UART Receiver with Sticky Overrun

This block receives asynchronous serial frames on one input line and hands each byte to a one-entry receive buffer. It has its own programmable baud tick generator, a 16x oversampling frame engine and a status unit with six flags: busy, reception finished, error sum, overrun, parity error and framing error. Each frame has eight data bits, least significant bit first, then an optional parity bit (even or odd) and one stop bit. A one-cycle data-ready pulse marks every byte that reaches the buffer, so a DMA engine can collect it without polling.

Overrun is sticky. If a frame completes while the previous byte is still unread, the buffer keeps the old byte and the overrun flag is set. From then on the receiver keeps decoding frames but throws each one away. The only recovery is to drop receive-enable, which clears every flag. The buffer-read strobe clears the finished flag and the error flags only while no overrun is pending. A new baud divisor is applied when the running count wraps, or at once if both directions are switched off. The transmit pin is held high.

Top module: `serial_rx_sticky`

## Requirements
- R1: The line is oversampled with one tick every DIV+1 clocks, so one bit lasts 16*(DIV+1) clocks. A falling edge starts a frame only if the line is still low 8 ticks later; a shorter low pulse is ignored. Each data bit is sampled 16 ticks after the previous sample, and the data is assembled least significant bit first.
- R2: With parity enabled (`par_en`=1), a parity bit follows the data. `par_odd`=0 means the data and parity bits together hold an even number of ones; `par_odd`=1 means an odd number. On a mismatch the frame loads with `err_par`=1.
- R3: A stop bit sampled low loads the frame with `err_frm`=1.
- R4: A frame completing while `rx_done`=0 and `err_ovr`=0 updates `rx_data`, sets `rx_done` and pulses `dreq` high for exactly one clock.
- R5: A frame completing while `rx_done`=1 leaves `rx_data` unchanged, sets `err_ovr` and gives no `dreq`.
- R6: While `err_ovr`=1, every further frame is decoded but discarded: `rx_data` and the flags stay unchanged and no `dreq` is raised.
- R7: With `rx_en`=0, `rx_done`, `err_ovr`, `err_par` and `err_frm` clear on the next clock and any frame in progress is abandoned (`rx_busy`=0). `rx_data` keeps its value.
- R8: While `err_ovr`=0, a `buf_rd` pulse clears `rx_done`, `err_par` and `err_frm`.
- R9: While `err_ovr`=1, `buf_rd` changes no flag.
- R10: `err_sum` is high exactly when any of `err_ovr`, `err_par` or `err_frm` is high.
- R11: `rx_busy` is high from an accepted start bit until the stop bit is sampled, and low when the receiver is idle.
- R12: A `div_wr` while `rx_en` or `tx_en` is high takes effect on the clock after the current tick count wraps. With both low, it takes effect at once.
- R13: `txd` stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idles high |
| rx_en | input | 1 | Receive enable; low clears all flags |
| tx_en | input | 1 | Transmit enable; only used to decide whether the baud generator is idle |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | New divisor value (one tick every value+1 clocks) |
| buf_rd | input | 1 | Read strobe for the buffer low byte |
| rx_data | output | DATA_W | Receive buffer |
| rx_busy | output | 1 | Frame in progress |
| rx_done | output | 1 | Reception finished, buffer holds unread data |
| err_sum | output | 1 | OR of the three error flags |
| err_ovr | output | 1 | Sticky overrun flag |
| err_par | output | 1 | Parity error of the buffered frame |
| err_frm | output | 1 | Framing error of the buffered frame |
| dreq | output | 1 | One-cycle data-ready request |
| txd | output | 1 | Transmit pin, held high |

## Verification
The bench drives back-to-back frames without reading the buffer, then drives more frames. A design whose overrun is not sticky would either overwrite the buffer or raise a data-ready pulse for a discarded frame, and the scoreboard would see an unexpected item. A buffer read after overrun must leave `rx_done` and `err_ovr` set. A design that cleared them would let a later frame load, and the bench checks both flags directly. The bench also drives a low glitch shorter than half a bit, which a receiver without mid-bit start validation would decode as a frame. Frames with bad parity and with a low stop bit are checked for their flags, and for the flags clearing on the next read. The bench switches to a new divisor while receiving is enabled and checks that frames at the new rate decode correctly. It also drops receive-enable in the middle of a frame and checks that the receiver aborts it.

// File: rtl/srx_pkg.sv
package srx_pkg;
    parameter int unsigned SRX_DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [SRX_DATA_W-1:0] data;
        logic                  perr;
        logic                  ferr;
    } rx_frame_t;
endpackage

// File: rtl/srx_baud_gen.sv
module srx_baud_gen #(
    parameter int unsigned DIV_W    = 12,
    parameter int unsigned DIV_INIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             tick,
    output logic [DIV_W-1:0] div_eff
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] pend;
        logic             pend_v;
    } bg_state_t;

    bg_state_t q, d;

    always_comb begin
        d    = q;
        tick = run && (q.cnt == '0);
        if (!run) begin
            d.cnt = q.div;
        end else if (q.cnt == '0) begin
            // count wrapped: a parked divisor is applied now
            if (q.pend_v) begin
                d.div    = q.pend;
                d.cnt    = q.pend;
                d.pend_v = 1'b0;
            end else begin
                d.cnt = q.div;
            end
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
        if (div_wr) begin
            if (!run) begin
                d.div    = div_wdata;
                d.cnt    = div_wdata;
                d.pend_v = 1'b0;
            end else begin
                d.pend   = div_wdata;
                d.pend_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt    <= DIV_W'(DIV_INIT);
            q.div    <= DIV_W'(DIV_INIT);
            q.pend   <= '0;
            q.pend_v <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign div_eff = q.div;
endmodule

// File: rtl/srx_frame_rx.sv
module srx_frame_rx
    import srx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      tick,
    input  logic      rxd,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      busy,
    output logic      frame_valid,
    output rx_frame_t frame
);
    localparam int unsigned OVS_W = $clog2(OVS);
    localparam int unsigned IDX_W = $clog2(SRX_DATA_W);
    localparam logic [OVS_W-1:0] MID  = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);
    localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(SRX_DATA_W - 1);

    typedef struct packed {
        logic                  sync1;
        logic                  sync2;
        logic                  prev;
        rx_state_e             state;
        logic [OVS_W-1:0]      ovs;
        logic [IDX_W-1:0]      idx;
        logic [SRX_DATA_W-1:0] shreg;
        logic                  par_acc;
        logic                  perr;
        logic                  valid;
        rx_frame_t             frame;
    } fr_state_t;

    fr_state_t q, d;
    logic      line;

    assign line = q.sync2;

    always_comb begin
        d       = q;
        d.sync1 = rxd;
        d.sync2 = q.sync1;
        d.prev  = line;
        d.valid = 1'b0;
        if (!en) begin
            d.state = RX_IDLE;
        end else begin
            unique case (q.state)
                RX_IDLE: begin
                    if (q.prev && !line) begin
                        d.state = RX_START;
                        d.ovs   = '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (q.ovs == MID) begin
                            d.ovs     = '0;
                            d.idx     = '0;
                            d.par_acc = 1'b0;
                            d.perr    = 1'b0;
                            d.state   = line ? RX_IDLE : RX_DATA;
                        end else begin
                            d.ovs = q.ovs + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (q.ovs == LAST) begin
                            d.ovs     = '0;
                            d.shreg   = {line, q.shreg[SRX_DATA_W-1:1]};
                            d.par_acc = q.par_acc ^ line;
                            if (q.idx == TOP_BIT) begin
                                d.state = par_en ? RX_PARITY : RX_STOP;
                            end else begin
                                d.idx = q.idx + 1'b1;
                            end
                        end else begin
                            d.ovs = q.ovs + 1'b1;
                        end
                    end
                end
                RX_PARITY: begin
                    if (tick) begin
                        if (q.ovs == LAST) begin
                            d.ovs   = '0;
                            d.perr  = ((q.par_acc ^ line) != par_odd);
                            d.state = RX_STOP;
                        end else begin
                            d.ovs = q.ovs + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (q.ovs == LAST) begin
                            d.ovs        = '0;
                            d.valid      = 1'b1;
                            d.frame.data = q.shreg;
                            d.frame.perr = q.perr;
                            d.frame.ferr = !line;
                            d.state      = RX_IDLE;
                        end else begin
                            d.ovs = q.ovs + 1'b1;
                        end
                    end
                end
                default: d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sync1 <= 1'b1;
            q.sync2 <= 1'b1;
            q.prev  <= 1'b1;
            q.state <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.state != RX_IDLE);
    assign frame_valid = q.valid;
    assign frame       = q.frame;
endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  buf_rd,
    input  logic                  frame_valid,
    input  rx_frame_t             frame,
    output logic [SRX_DATA_W-1:0] rx_data,
    output logic                  done,
    output logic                  ovr,
    output logic                  perr,
    output logic                  ferr,
    output logic                  dreq
);
    typedef struct packed {
        logic [SRX_DATA_W-1:0] buffer;
        logic                  done;
        logic                  ovr;
        logic                  perr;
        logic                  ferr;
        logic                  dreq;
    } st_state_t;

    st_state_t q, d;

    always_comb begin
        d      = q;
        d.dreq = 1'b0;
        if (!en) begin
            d.done = 1'b0;
            d.ovr  = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
        end else begin
            // reads only count while no overrun is pending
            if (buf_rd && !q.ovr) begin
                d.done = 1'b0;
                d.perr = 1'b0;
                d.ferr = 1'b0;
            end
            if (frame_valid && !q.ovr) begin
                if (d.done) begin
                    d.ovr = 1'b1;
                end else begin
                    d.buffer = frame.data;
                    d.done   = 1'b1;
                    d.perr   = frame.perr;
                    d.ferr   = frame.ferr;
                    d.dreq   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_data = q.buffer;
    assign done    = q.done;
    assign ovr     = q.ovr;
    assign perr    = q.perr;
    assign ferr    = q.ferr;
    assign dreq    = q.dreq;
endmodule

// File: rtl/serial_rx_sticky.sv
module serial_rx_sticky
    import srx_pkg::*;
#(
    parameter int unsigned DIV_W    = 12,
    parameter int unsigned DIV_INIT = 3,
    parameter int unsigned OVS      = 16,
    parameter int unsigned DATA_W   = SRX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_busy,
    output logic              rx_done,
    output logic              err_sum,
    output logic              err_ovr,
    output logic              err_par,
    output logic              err_frm,
    output logic              dreq,
    output logic              txd
);
    logic             baud_run;
    logic             baud_tick;
    logic [DIV_W-1:0] div_eff;
    logic             fr_valid;
    rx_frame_t        fr_data;

    assign baud_run = rx_en | tx_en;

    srx_baud_gen #(
        .DIV_W   (DIV_W),
        .DIV_INIT(DIV_INIT)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (baud_run),
        .div_wr   (div_wr),
        .div_wdata(div_wdata),
        .tick     (baud_tick),
        .div_eff  (div_eff)
    );

    srx_frame_rx #(
        .OVS(OVS)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rx_en),
        .tick       (baud_tick),
        .rxd        (rxd),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .busy       (rx_busy),
        .frame_valid(fr_valid),
        .frame      (fr_data)
    );

    srx_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rx_en),
        .buf_rd     (buf_rd),
        .frame_valid(fr_valid),
        .frame      (fr_data),
        .rx_data    (rx_data),
        .done       (rx_done),
        .ovr        (err_ovr),
        .perr       (err_par),
        .ferr       (err_frm),
        .dreq       (dreq)
    );

    assign err_sum = err_ovr | err_par | err_frm;
    assign txd     = 1'b1;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int unsigned DIV_W  = 12,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              buf_rd,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_done,
    input logic              err_ovr,
    input logic              err_sum,
    input logic              dreq,
    input logic              baud_run,
    input logic              baud_tick,
    input logic [DIV_W-1:0]  div_eff
);
    AST_DREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |=> !dreq); // R4
    AST_DREQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> rx_done); // R4
    AST_OVR_FREEZES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovr |=> $stable(rx_data)); // R6
    AST_OVR_NO_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovr |-> !dreq); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr && rx_en) |=> err_ovr); // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!err_ovr && !rx_done && !err_sum)); // R7
    AST_READ_IGNORED_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr && rx_en && buf_rd) |=> rx_done); // R9
    AST_DIV_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_eff) |-> ($past(baud_tick) || !$past(baud_run))); // R12
endmodule

bind serial_rx_sticky srx_checker #(
    .DIV_W (DIV_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .buf_rd   (buf_rd),
    .rx_data  (rx_data),
    .rx_done  (rx_done),
    .err_ovr  (err_ovr),
    .err_sum  (err_sum),
    .dreq     (dreq),
    .baud_run (baud_run),
    .baud_tick(baud_tick),
    .div_eff  (div_eff)
);

// File: tb/serial_rx_sticky_test.sv
module serial_rx_sticky_test;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rxd = 1'b1;
    logic             rx_en = 1'b0;
    logic             tx_en = 1'b0;
    logic             par_en = 1'b0;
    logic             par_odd = 1'b0;
    logic             div_wr = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             buf_rd = 1'b0;
    logic [7:0]       rx_data;
    logic             rx_busy, rx_done, err_sum, err_ovr, err_par, err_frm, dreq, txd;

    int checks = 0;
    int failures = 0;
    int bit_clks = 64;
    bit finished = 1'b0;

    typedef struct packed {
        logic [7:0] d;
        logic       p;
        logic       f;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    serial_rx_sticky #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .tx_en(tx_en),
        .par_en(par_en), .par_odd(par_odd), .div_wr(div_wr), .div_wdata(div_wdata),
        .buf_rd(buf_rd), .rx_data(rx_data), .rx_busy(rx_busy), .rx_done(rx_done),
        .err_sum(err_sum), .err_ovr(err_ovr), .err_par(err_par), .err_frm(err_frm),
        .dreq(dreq), .txd(txd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a byte reaches the buffer
    always @(negedge clk) begin
        if (rst_n && dreq) begin
            if (expq.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R5/R6 unexpected dreq actual=%0h expected=none", rx_data);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk("R1 data", {24'd0, rx_data}, {24'd0, e.d});
                chk("R2 parity flag", {31'd0, err_par}, {31'd0, e.p});
                chk("R3 framing flag", {31'd0, err_frm}, {31'd0, e.f});
                chk("R4 done on load", {31'd0, rx_done}, 32'd1);
            end
        end
    end

    task automatic set_div(input int v);
        @(negedge clk);
        div_wr = 1'b1;
        div_wdata = DIV_W'(v);
        @(negedge clk);
        div_wr = 1'b0;
        bit_clks = 16 * (v + 1);
    endtask

    task automatic hold_bit(input logic b);
        rxd = b;
        repeat (bit_clks) @(negedge clk);
    endtask

    // driver: sends one frame and pushes the expected buffer item
    task automatic send(input logic [7:0] dat, input bit stop_hi, input bit bad_par,
                        input bit loads);
        if (loads) expq.push_back('{d: dat, p: par_en && bad_par, f: !stop_hi});
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) begin
            if (i == 4) begin
                rxd = dat[i];
                repeat (bit_clks / 2) @(negedge clk);
                chk("R11 busy mid-frame", {31'd0, rx_busy}, 32'd1);
                repeat (bit_clks - bit_clks / 2) @(negedge clk);
            end else begin
                hold_bit(dat[i]);
            end
        end
        if (par_en) hold_bit((^dat) ^ par_odd ^ bad_par);
        hold_bit(stop_hi);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic read_buf;
        @(negedge clk);
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R4 reset done", {31'd0, rx_done}, 32'd0);
        chk("R10 reset sum", {31'd0, err_sum}, 32'd0);
        chk("R11 reset busy", {31'd0, rx_busy}, 32'd0);
        chk("R13 txd in reset", {31'd0, txd}, 32'd1);
        rst_n = 1'b1;

        // R12: immediate divisor load while both directions are off
        set_div(3);
        @(negedge clk);
        rx_en = 1'b1;
        repeat (5) @(negedge clk);

        send(8'hA5, 1'b1, 1'b0, 1'b1);
        chk("R11 idle after frame", {31'd0, rx_busy}, 32'd0);
        chk("R13 txd idle", {31'd0, txd}, 32'd1);
        read_buf();
        chk("R8 read clears done", {31'd0, rx_done}, 32'd0);

        // R1: glitch shorter than half a bit is rejected
        @(negedge clk);
        rxd = 1'b0;
        repeat (bit_clks / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * bit_clks) @(negedge clk);
        chk("R1 glitch no busy", {31'd0, rx_busy}, 32'd0);
        chk("R1 glitch no load", {31'd0, rx_done}, 32'd0);

        // R2: even then odd parity
        par_en = 1'b1;
        par_odd = 1'b0;
        send(8'h3C, 1'b1, 1'b0, 1'b1);
        read_buf();
        send(8'h3D, 1'b1, 1'b1, 1'b1);
        chk("R10 sum with parity error", {31'd0, err_sum}, 32'd1);
        read_buf();
        chk("R8 read clears parity", {31'd0, err_par}, 32'd0);
        chk("R10 sum clear", {31'd0, err_sum}, 32'd0);
        par_odd = 1'b1;
        send(8'h81, 1'b1, 1'b0, 1'b1);
        read_buf();
        send(8'h7E, 1'b1, 1'b1, 1'b1);
        read_buf();
        par_en = 1'b0;
        par_odd = 1'b0;

        // R3: low stop bit
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        chk("R10 sum with framing error", {31'd0, err_sum}, 32'd1);
        read_buf();
        chk("R8 read clears framing", {31'd0, err_frm}, 32'd0);

        // R5/R6/R9: sticky overrun
        send(8'h11, 1'b1, 1'b0, 1'b1);
        send(8'h22, 1'b1, 1'b0, 1'b0);
        chk("R5 overrun set", {31'd0, err_ovr}, 32'd1);
        chk("R5 buffer kept", {24'd0, rx_data}, 32'h11);
        chk("R10 sum on overrun", {31'd0, err_sum}, 32'd1);
        read_buf();
        chk("R9 read keeps done", {31'd0, rx_done}, 32'd1);
        chk("R9 read keeps overrun", {31'd0, err_ovr}, 32'd1);
        send(8'h33, 1'b1, 1'b0, 1'b0);
        chk("R6 discarded frame", {24'd0, rx_data}, 32'h11);
        chk("R6 still overrun", {31'd0, err_ovr}, 32'd1);

        // R7: disable clears flags, keeps buffer
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R7 overrun cleared", {31'd0, err_ovr}, 32'd0);
        chk("R7 done cleared", {31'd0, rx_done}, 32'd0);
        chk("R7 buffer kept", {24'd0, rx_data}, 32'h11);
        rx_en = 1'b1;
        repeat (3) @(negedge clk);
        send(8'h44, 1'b1, 1'b0, 1'b1);
        read_buf();

        // R7: abort mid-frame
        @(negedge clk);
        rxd = 1'b0;
        repeat (3 * bit_clks) @(negedge clk);
        chk("R11 busy during frame", {31'd0, rx_busy}, 32'd1);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 abort busy low", {31'd0, rx_busy}, 32'd0);
        rxd = 1'b1;
        repeat (bit_clks) @(negedge clk);
        rx_en = 1'b1;
        repeat (2 * bit_clks) @(negedge clk);

        // R12: deferred divisor write while receiving is enabled
        set_div(5);
        repeat (20) @(negedge clk);
        send(8'hC3, 1'b1, 1'b0, 1'b1);
        read_buf();
        send(8'h0F, 1'b1, 1'b0, 1'b1);
        read_buf();
        chk("R4 final done clear", {31'd0, rx_done}, 32'd0);

        repeat (10) @(negedge clk);
        chk("R4 scoreboard drained", expq.size(), 32'd0);
        finish_run();
    end
endmodule